// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor with Split Instruction and Data Memories

This block is a small accumulator machine. It reads 10-bit instructions through a read-only port that addresses a 32-word program store. It operates on 8-bit values kept in an internal 32-word data RAM that only it can write. Its state is a program counter, an accumulator, a multiplier/quotient register (MQ), an address latch, a data buffer, an instruction latch, and two flags: carry and signed overflow. The program store sits outside the block, and the CPU never writes to it.

Opcodes vary in length. A `10` prefix carries an 8-bit immediate. Five-bit opcodes that start with `0` carry a 5-bit address, or no operand for the I/O pair. Six-bit opcodes that start with `11` work on the accumulator and MQ implicitly. A four-state sequencer runs each instruction: fetch, decode/execute, memory read, then memory execute. The number of cycles depends on the instruction's group.

The only ways to see the machine from outside are an 8-bit switch input and an 8-bit output register. The output register comes with a one-cycle valid strobe.

Top module: `harvard_acc_cpu`

## Requirements
- R1: Synchronous active-high reset clears PC, accumulator, MQ and both flags, deasserts `out_valid`, and fetching restarts at address 0.
- R2: An instruction whose bits [9:8] are `10` loads bits [7:0] into the accumulator. Such an instruction, and every jump, I/O and implicit-operand instruction, takes 2 cycles (fetch plus execute).
- R3: LOADM (`00000`) copies data RAM at address bits [4:0] into the accumulator in 4 cycles. STORM (`00001`) writes the accumulator to that address in 3 cycles.
- R4: ADD (`00110`) adds the RAM word to the accumulator modulo 256. It sets carry to the unsigned carry out and overflow to signed overflow. AND (`00111`) stores the bitwise AND and leaves both flags unchanged.
- R5: JUMPM (`00010`) always loads PC from bits [4:0].
- R6: JUMP_MQ (`00011`) jumps when MQ bit 7 is 0 and falls through otherwise.
- R7: JUMP_C (`00100`) jumps when carry is set. JUMP_OF (`00101`) jumps when overflow is set. A jump that is not taken advances PC by one.
- R8: STOR_IO (`01000`) puts the accumulator on `out_port` and pulses `out_valid` for one cycle; the pulse is visible after the second clock of the instruction. LOAD_IO (`01001`) loads `sw_in` into the accumulator. Bits [4:0] of both are ignored.
- R9: INC (`110010`) and DEC (`110100`) change the accumulator by one. They set overflow only on 0x7F→0x80 or 0x80→0x7F, clear it otherwise, and leave carry unchanged.
- R10: LSH (`110110`) and RSH (`111000`) shift by one with zero fill and put the bit shifted out into carry. INV (`111010`) complements the accumulator. Overflow is not changed by any of these three.
- R11: SWAP (`111100`) exchanges MQ and the accumulator. LOAD_MMQ (`111110`) loads data RAM at address MQ[4:0] into the accumulator, in 4 cycles.
- R12: Any other encoding (for example `01010xxxxx` or `110000xxxx`) changes no state except advancing PC.
- R13: PC wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 5 | Program store address (the PC) |
| imem_data | input | 10 | Program word at `imem_addr` |
| sw_in | input | 8 | Switch input read by LOAD_IO |
| out_port | output | 8 | Output register written by STOR_IO |
| out_valid | output | 1 | One-cycle strobe when `out_port` is written |

## Verification
Every internal register is reachable only through the program and the output port. The flags and MQ are the hardest to observe. Each flag test therefore follows the flag-setting instruction with a conditional jump over a `LOAD 0xEE; STOR_IO` pair. A wrong branch decision shows up as an extra or a missing output item on the scoreboard. The PC wrap is reached by jumping near the top of the program store and letting execution run past address 31 into code at address 0. That code uses MQ, loaded by SWAP, to choose a different path on its second pass.

// File: rtl/harvard_acc_cpu.sv
module harvard_acc_cpu #(
  parameter int DW = 8,
  localparam int IW = DW + 2,
  localparam int AW = IW - 5,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_data,
  input  logic [DW-1:0] sw_in,
  output logic [DW-1:0] out_port,
  output logic          out_valid
);

  localparam logic [4:0] OP_LOADM = 5'b00000, OP_STORM = 5'b00001, OP_JMP = 5'b00010,
                         OP_JMQ = 5'b00011, OP_JC = 5'b00100, OP_JOF = 5'b00101,
                         OP_ADD = 5'b00110, OP_AND = 5'b00111, OP_OUT = 5'b01000,
                         OP_IN = 5'b01001;
  localparam logic [5:0] OP_INC = 6'b110010, OP_DEC = 6'b110100, OP_LSH = 6'b110110,
                         OP_RSH = 6'b111000, OP_INV = 6'b111010, OP_SWAP = 6'b111100,
                         OP_LDMQ = 6'b111110;
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {S_FETCH, S_DECODE, S_MEMRD, S_EXEC} state_t;

  state_t        st;
  logic [IW-1:0] ir;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] acc, mq, mbr;
  logic          fl_c, fl_v;
  logic [DW-1:0] dmem [DEPTH];

  wire [4:0]    op5 = ir[IW-1 -: 5];
  wire [5:0]    op6 = ir[IW-1 -: 6];
  wire [AW-1:0] fld = ir[AW-1:0];
  wire is_imm   = ir[IW-1 -: 2] == 2'b10;
  wire is_store = op5 == OP_STORM;
  wire is_mem   = op5 == OP_LOADM || is_store || op5 == OP_ADD || op5 == OP_AND || op6 == OP_LDMQ;
  wire is_jump  = op5 == OP_JMP || op5 == OP_JMQ || op5 == OP_JC || op5 == OP_JOF;
  wire [DW:0] sum = {1'b0, acc} + {1'b0, mbr};
  wire add_ovf  = (acc[DW-1] == mbr[DW-1]) && (sum[DW-1] != acc[DW-1]);

  logic jump_take;
  always_comb begin
    case (op5)
      OP_JMP:  jump_take = 1'b1;
      OP_JMQ:  jump_take = !mq[DW-1];
      OP_JC:   jump_take = fl_c;
      OP_JOF:  jump_take = fl_v;
      default: jump_take = 1'b0;
    endcase
  end

  assign imem_addr = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH;
      pc <= '0;
      acc <= '0;
      mq <= '0;
      fl_c <= 1'b0;
      fl_v <= 1'b0;
      ir <= '0;
      mar <= '0;
      mbr <= '0;
      out_port <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_FETCH: begin
          ir <= imem_data;
          st <= S_DECODE;
        end
        S_DECODE: begin
          st <= S_FETCH;
          pc <= pc + AW'(1);
          if (is_imm) begin
            acc <= ir[DW-1:0];
          end else if (is_mem) begin
            mar <= (op6 == OP_LDMQ) ? mq[AW-1:0] : fld;
            pc <= pc;
            st <= S_MEMRD;
          end else if (is_jump) begin
            if (jump_take) pc <= fld;
          end else if (op5 == OP_OUT) begin
            out_port <= acc;
            out_valid <= 1'b1;
          end else if (op5 == OP_IN) begin
            acc <= sw_in;
          end else begin
            case (op6)
              OP_INC: begin
                acc <= acc + DW'(1);
                fl_v <= acc == POS_MAX;
              end
              OP_DEC: begin
                acc <= acc - DW'(1);
                fl_v <= acc == NEG_MIN;
              end
              OP_LSH:  {fl_c, acc} <= {acc, 1'b0};
              OP_RSH:  {acc, fl_c} <= {1'b0, acc};
              OP_INV:  acc <= ~acc;
              OP_SWAP: begin
                acc <= mq;
                mq <= acc;
              end
              default: ;
            endcase
          end
        end
        S_MEMRD: begin
          mbr <= dmem[mar];
          if (is_store) begin
            pc <= pc + AW'(1);
            st <= S_FETCH;
          end else begin
            st <= S_EXEC;
          end
        end
        S_EXEC: begin
          pc <= pc + AW'(1);
          st <= S_FETCH;
          if (op5 == OP_ADD) begin
            acc <= sum[DW-1:0];
            fl_c <= sum[DW];
            fl_v <= add_ovf;
          end else if (op5 == OP_AND) begin
            acc <= acc & mbr;
          end else begin
            acc <= mbr;
          end
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && st == S_MEMRD && is_store) dmem[mar] <= acc;
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0 && acc == '0 && mq == '0 && !fl_c && !fl_v && st == S_FETCH && !out_valid));

  p_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    st == S_FETCH |=> st == S_DECODE);

  p_store_len_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_MEMRD && is_store) |=> st == S_FETCH);

  p_load_len_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_MEMRD && !is_store) |=> st == S_EXEC);

  p_jump_target_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECODE && is_jump && jump_take) |=> pc == $past(fld));

  p_pc_step_r13: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECODE && !is_mem && !(is_jump && jump_take)) |=> pc == $past(pc) + AW'(1));

  p_out_acc_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_port == acc);

endmodule

// File: tb/harvard_acc_cpu_test.sv
module harvard_acc_cpu_test;
  localparam logic [4:0] LOADM = 5'b00000, STORM = 5'b00001, JMP = 5'b00010, JMQ = 5'b00011,
                         JC = 5'b00100, JOF = 5'b00101, ADD = 5'b00110, ANDM = 5'b00111,
                         OUTP = 5'b01000, INP = 5'b01001;
  localparam logic [5:0] INC = 6'b110010, DEC = 6'b110100, LSH = 6'b110110, RSH = 6'b111000,
                         INV = 6'b111010, SWAP = 6'b111100, LDMQ = 6'b111110;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [9:0] rom [32];
  logic [4:0] imem_addr;
  logic [9:0] imem_data;
  logic [7:0] sw_in = 8'h00, out_port;
  logic       out_valid;
  assign imem_data = rom[imem_addr];

  harvard_acc_cpu uut (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
                       .sw_in(sw_in), .out_port(out_port), .out_valid(out_valid));

  int n_chk = 0, n_bad = 0, cyc = 0, ip = 0;
  bit finished = 0;
  logic [7:0] q_val [$];
  int         q_cyc [$];
  string      q_tag [$];
  logic [7:0] m_val;
  int         m_cyc;
  string      m_tag;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_val.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL unexpected output: actual %0h expected none", out_port);
      end else begin
        m_val = q_val.pop_front();
        m_cyc = q_cyc.pop_front();
        m_tag = q_tag.pop_front();
        check(m_tag, out_port, m_val);
        if (m_cyc >= 0) check({m_tag, " cycle"}, cyc, m_cyc);
      end
    end
  end

  task automatic expect_out(logic [7:0] v, int c, string tag);
    q_val.push_back(v);
    q_cyc.push_back(c);
    q_tag.push_back(tag);
  endtask

  function automatic logic [9:0] f_imm(logic [7:0] v);
    return {2'b10, v};
  endfunction
  function automatic logic [9:0] f_m(logic [4:0] op, int a);
    return {op, 5'(a)};
  endfunction
  function automatic logic [9:0] f_i(logic [5:0] op);
    return {op, 4'b0000};
  endfunction

  task automatic new_prog();
    for (int i = 0; i < 32; i++) rom[i] = 10'b0;
    ip = 0;
  endtask
  task automatic emit(logic [9:0] w);
    rom[ip] = w;
    ip++;
  endtask
  task automatic halt();
    emit(f_m(JMP, ip));
  endtask

  task automatic run_prog();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset pc", imem_addr, 0);
    check("R1 reset strobe", out_valid, 0);
    rst = 1'b0;
    for (int i = 0; i < 3000 && q_val.size() != 0; i++) @(negedge clk);
    while (q_val.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s: actual none expected %0h", q_tag.pop_front(), q_val.pop_front());
      void'(q_cyc.pop_front());
    end
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // T1: reset state, immediate, I/O, 2-cycle timing
    new_prog();
    emit({OUTP, 5'b00000});
    emit(f_imm(8'hA5));
    emit({OUTP, 5'b10101});
    emit({INP, 5'b11111});
    emit({OUTP, 5'b11111});
    halt();
    sw_in = 8'h3C;
    expect_out(8'h00, 2, "R1 acc after reset");
    expect_out(8'hA5, 6, "R2 immediate load");
    expect_out(8'h3C, 10, "R8 switch input");
    run_prog();

    // T2: memory store and load timing
    new_prog();
    emit(f_imm(8'h11)); emit(f_m(STORM, 3));
    emit(f_imm(8'h22)); emit(f_m(STORM, 4));
    emit(f_m(LOADM, 3)); emit({OUTP, 5'b0});
    emit(f_m(LOADM, 4)); emit({OUTP, 5'b0});
    halt();
    expect_out(8'h11, 16, "R3 loadm addr 3");
    expect_out(8'h22, 22, "R3 loadm addr 4");
    run_prog();

    // T3: ADD flags and conditional jumps
    new_prog();
    emit(f_imm(8'h70)); emit(f_m(STORM, 1)); emit(f_imm(8'h20)); emit(f_m(ADD, 1));
    emit({OUTP, 5'b0});
    emit(f_m(JOF, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(f_imm(8'h01)); emit({OUTP, 5'b0});
    emit(f_m(JC, ip + 3)); emit(f_imm(8'h02)); emit({OUTP, 5'b0});
    emit(f_imm(8'hFF)); emit(f_m(STORM, 2)); emit(f_imm(8'h01)); emit(f_m(ADD, 2));
    emit({OUTP, 5'b0});
    emit(f_m(JC, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(f_imm(8'h04)); emit({OUTP, 5'b0});
    emit(f_m(JOF, ip + 3)); emit(f_imm(8'h05)); emit({OUTP, 5'b0});
    halt();
    expect_out(8'h90, -1, "R4 add signed overflow");
    expect_out(8'h01, -1, "R7 jump_of taken");
    expect_out(8'h02, -1, "R7 jump_c not taken");
    expect_out(8'h00, -1, "R4 add carry out");
    expect_out(8'h04, -1, "R7 jump_c taken");
    expect_out(8'h05, -1, "R7 jump_of not taken");
    run_prog();

    // T4: AND keeps flags, INC/DEC overflow
    new_prog();
    emit(f_imm(8'h81)); emit(f_i(LSH));
    emit(f_imm(8'hF0)); emit(f_m(STORM, 5)); emit(f_imm(8'h3C)); emit(f_m(ANDM, 5));
    emit({OUTP, 5'b0});
    emit(f_m(JC, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(f_imm(8'h7F)); emit(f_i(INC)); emit({OUTP, 5'b0});
    emit(f_m(JOF, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(f_imm(8'h80)); emit(f_i(DEC)); emit({OUTP, 5'b0});
    emit(f_m(JOF, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(f_imm(8'h10)); emit(f_i(INC)); emit({OUTP, 5'b0});
    emit(f_m(JOF, ip + 3)); emit(f_imm(8'h06)); emit({OUTP, 5'b0});
    halt();
    expect_out(8'h30, -1, "R4 and result");
    expect_out(8'h80, -1, "R9 inc 7f");
    expect_out(8'h7F, -1, "R9 dec 80");
    expect_out(8'h11, -1, "R9 inc plain");
    expect_out(8'h06, -1, "R9 overflow cleared");
    run_prog();

    // T5: shifts and invert
    new_prog();
    emit(f_imm(8'h81)); emit(f_i(LSH)); emit({OUTP, 5'b0});
    emit(f_m(JC, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(f_imm(8'h02)); emit(f_i(RSH)); emit({OUTP, 5'b0});
    emit(f_m(JC, ip + 3)); emit(f_imm(8'h07)); emit({OUTP, 5'b0});
    emit(f_imm(8'h5A)); emit(f_i(INV)); emit({OUTP, 5'b0});
    emit(f_imm(8'h80)); emit(f_i(RSH)); emit({OUTP, 5'b0});
    emit(f_imm(8'h01)); emit(f_i(RSH)); emit({OUTP, 5'b0});
    emit(f_m(JC, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    halt();
    expect_out(8'h02, -1, "R10 lsh");
    expect_out(8'h01, -1, "R10 rsh");
    expect_out(8'h07, -1, "R10 rsh carry clear");
    expect_out(8'hA5, -1, "R10 inv");
    expect_out(8'h40, -1, "R10 rsh zero fill");
    expect_out(8'h00, -1, "R10 rsh carry out");
    run_prog();

    // T6: SWAP, MQ jump, MQ-indirect load, undefined opcodes
    new_prog();
    emit(f_imm(8'h85)); emit(f_i(SWAP)); emit({OUTP, 5'b0});
    emit(f_m(JMQ, ip + 3)); emit(f_imm(8'h08)); emit({OUTP, 5'b0});
    emit(f_imm(8'h04)); emit(f_i(SWAP)); emit({OUTP, 5'b0});
    emit(f_imm(8'h99)); emit(f_m(STORM, 4)); emit(f_imm(8'h00)); emit(f_i(LDMQ));
    emit({OUTP, 5'b0});
    emit(f_m(JMQ, ip + 3)); emit(f_imm(8'hEE)); emit({OUTP, 5'b0});
    emit(10'b0101000000); emit(10'b1100000000);
    emit({OUTP, 5'b0});
    halt();
    expect_out(8'h00, -1, "R11 swap to acc");
    expect_out(8'h08, -1, "R6 jump_mq negative not taken");
    expect_out(8'h85, -1, "R11 swap back");
    expect_out(8'h99, -1, "R11 load via mq");
    expect_out(8'h99, -1, "R12 undefined no-op");
    run_prog();

    // T7: PC wrap, MQ jump taken, unconditional jump
    new_prog();
    rom[0] = f_i(SWAP);
    rom[1] = f_m(JMQ, 29);
    rom[2] = {OUTP, 5'b0};
    rom[3] = f_m(JMP, 6);
    rom[4] = f_imm(8'hEE);
    rom[5] = {OUTP, 5'b0};
    rom[6] = f_imm(8'h55);
    rom[7] = {OUTP, 5'b0};
    rom[8] = f_m(JMP, 8);
    rom[29] = f_imm(8'h33);
    rom[30] = {OUTP, 5'b0};
    rom[31] = f_imm(8'h80);
    expect_out(8'h33, -1, "R6 jump_mq taken");
    expect_out(8'h00, -1, "R13 pc wrap");
    expect_out(8'h55, -1, "R5 unconditional jump");
    run_prog();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule